// File: doc/BRIEF.md
# Connection-Context Table Accessor with Clear-on-Read

This block stands between a host register port and a single-port SRAM. The SRAM holds 64-bit connection-context words. Each word is addressed by a connection index and a row number. The host asks for a plain read, a plain write or a masked write. Reads can run in clear-on-read mode, where the block writes the word back by itself straight after reading it. Which bits are cleared depends on the row that was read. Bits set in a programmable protection mask are never changed by a write-back.

The SRAM is shared with other engines, which work in fixed cell-period slots. The block takes the bus at most once per slot. A slot begins when the slot strobe is seen. A request that finds its slot already used stays pending until a later strobe.

A plain access holds the SRAM bus for one cycle. A read followed by a write-back holds it for four cycles: the read, two turnaround cycles, then the write. The host sees busy from the cycle after its request until the done pulse. The returned data is the word as it stood before any clearing.

Top module: `ctx_table_access`

## Requirements
- R1: With clear-on-read set, a read of row 5 is followed by a write-back of the same address. In that write-back, bits [47:0] become 0, except bits protected by the mask, and bits [63:48] keep their old value.
- R2: With clear-on-read set, a read of row 6 or row 9 is followed by a write-back in which every bit not protected by the mask becomes 0.
- R3: In every write-back, whether clear-on-read or masked write, each bit whose protection-mask bit is 1 keeps its old value. The mask is loaded from `mask_data` on a cycle with `mask_load` high.
- R4: With clear-on-read clear, or on a read of any row other than 5, 6 or 9, a read leaves the SRAM word unchanged and issues no write.
- R5: A plain read or plain write uses exactly one SRAM bus cycle (`sram_en` high). A clear-on-read write-back or a masked write uses a four-cycle window: a read in the first cycle, no bus activity in the second and third, and the write in the fourth. The SRAM returns read data on the cycle after `sram_en` with `sram_we` low. The address is {index, row}, with the row in the low bits.
- R6: At most one host access starts per slot, a slot being the interval between two slot-strobe pulses. No access starts in a cycle where the strobe is high. A request made after its slot is used waits for a later strobe and is always served.
- R7: A request is taken when `req` is high and `busy` is low. `busy` is high from the next cycle until the cycle in which `done` pulses for one cycle. In that cycle `busy` is low again.
- R8: For reads, `rdata` shows, from the `done` pulse on, the word as it was read, before any clearing.
- R9: A masked write stores the new data where the mask bit is 0 and the old word where it is 1. A plain write stores the full new word regardless of the mask.
- R10: After reset, `busy`, `done`, `sram_en` and `sram_we` are low, and the first access waits for the first slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_strobe | input | 1 | One-cycle pulse marking the start of a cell-period slot |
| req | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_masked | input | 1 | With req_write: merge under the protection mask |
| req_index | input | IDX_W | Connection index |
| req_row | input | ROW_W | Row number in the context |
| req_wdata | input | WORD_W | Write data |
| cor_en | input | 1 | Clear-on-read control, sampled with the request |
| mask_load | input | 1 | Load the protection mask |
| mask_data | input | WORD_W | New protection mask value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | WORD_W | Captured read word |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | IDX_W+ROW_W | SRAM address {index,row} |
| sram_wdata | output | WORD_W | SRAM write data |
| sram_rdata | input | WORD_W | SRAM read data, one cycle after the read |

## Verification
Random accesses mix plain reads, plain writes and masked writes, run under random masks, and cover clear-on-read on and off across all rows. These tell the row-5 partial clear apart from the full clear on rows 6 and 9 and from the rows that are left alone. The bench checks the returned word against the pre-clear value, the stored word against its own merge, and the length of each access window (one cycle or four). Directed cases first use a slot, then request again inside it, to show the second request is held until the next strobe. Dense all-ones and all-zeros masks show that protected bits survive and that an unmasked clear removes every bit it should.

// File: rtl/ctx_acc_pkg.sv
package ctx_acc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_CAP  = 3'd2,
    ST_TURN = 3'd3,
    ST_WR   = 3'd4
  } acc_state_t;
endpackage

// File: rtl/ctx_slot_gate.sv
module ctx_slot_gate (
  input  logic clk,
  input  logic rst,
  input  logic slot_strobe,
  input  logic want,
  output logic grant
);
  logic avail_q;

  // a strobe cycle never grants, so every slot opens fresh
  assign grant = want && avail_q && !slot_strobe;

  always_ff @(posedge clk) begin
    if (rst)              avail_q <= 1'b0;
    else if (slot_strobe) avail_q <= 1'b1;
    else if (grant)       avail_q <= 1'b0;
  end

  assert_slot_spent_R6: assert property (@(posedge clk) disable iff (rst)
    grant |=> !avail_q);
  assert_no_grant_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    slot_strobe |-> !grant);
endmodule

// File: rtl/ctx_wb_merge.sv
module ctx_wb_merge #(
  parameter int WORD_W   = 64,
  parameter int ROW_W    = 4,
  parameter int PART_ROW = 5,
  parameter int KEEP_LSB = 48
) (
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [WORD_W-1:0] wmask,
  input  logic [ROW_W-1:0]  row,
  input  logic              masked_wr,
  output logic [WORD_W-1:0] merged
);
  localparam logic [WORD_W-1:0] HI_KEEP =
    {{(WORD_W-KEEP_LSB){1'b1}}, {KEEP_LSB{1'b0}}};

  logic [WORD_W-1:0] keep;

  always_comb begin
    keep = wmask;
    if (!masked_wr && (row == ROW_W'(PART_ROW))) keep = wmask | HI_KEEP;
    if (masked_wr) merged = (new_word & ~wmask) | (old_word & wmask);
    else           merged = old_word & keep;
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_acc_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int IDX_W      = 4,
  parameter int ROW_W      = 4,
  parameter int PART_ROW   = 5,
  parameter int FULL_ROW_A = 6,
  parameter int FULL_ROW_B = 9,
  parameter int KEEP_LSB   = 48,
  localparam int ADDR_W    = IDX_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_masked,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              cor_en,
  input  logic              grant,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] merged,
  input  logic [WORD_W-1:0] sram_rdata,
  output logic              want,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] old_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [ROW_W-1:0]  row_q,
  output logic              masked_q,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [WORD_W-1:0] sram_wdata
);
  acc_state_t       state;
  logic             write_q, cor_q, wb_q;
  logic [IDX_W-1:0] idx_q;
  logic             clear_row;

  assign clear_row = (row_q == ROW_W'(PART_ROW)) || (row_q == ROW_W'(FULL_ROW_A)) ||
                     (row_q == ROW_W'(FULL_ROW_B));
  assign want       = busy && (state == ST_IDLE);
  assign sram_en    = (state == ST_RD) || (state == ST_WR);
  assign sram_we    = (state == ST_WR);
  assign sram_addr  = {idx_q, row_q};
  assign sram_wdata = wb_q ? merged : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      write_q  <= 1'b0;
      masked_q <= 1'b0;
      cor_q    <= 1'b0;
      wb_q     <= 1'b0;
      idx_q    <= '0;
      row_q    <= '0;
      wdata_q  <= '0;
      old_q    <= '0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!busy && req) begin
            busy     <= 1'b1;
            write_q  <= req_write;
            masked_q <= req_write && req_masked;
            cor_q    <= cor_en && !req_write;
            idx_q    <= req_index;
            row_q    <= req_row;
            wdata_q  <= req_wdata;
            wb_q     <= 1'b0;
          end else if (grant) begin
            state <= (write_q && !masked_q) ? ST_WR : ST_RD;
          end
        end
        ST_RD: state <= ST_CAP;
        ST_CAP: begin
          old_q <= sram_rdata;
          if (!write_q) rdata <= sram_rdata;
          if (masked_q || (cor_q && clear_row)) begin
            wb_q  <= 1'b1;
            state <= ST_TURN;
          end else begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_TURN: state <= ST_WR;
        ST_WR: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          wb_q  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_mask_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (sram_we && wb_q) |-> (((sram_wdata ^ old_q) & wmask) == '0));
  assert_low_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    (sram_we && wb_q && !masked_q && row_q == ROW_W'(PART_ROW)) |->
      ((sram_wdata[KEEP_LSB-1:0] & ~wmask[KEEP_LSB-1:0]) == '0));
  assert_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAP && !masked_q && !(cor_q && clear_row)) |=> !sram_en);
  assert_rmw_window_R5: assert property (@(posedge clk) disable iff (rst)
    (sram_we && wb_q) |-> ($past(sram_en, 3) && !$past(sram_en, 1) && !$past(sram_en, 2)));
  assert_start_on_grant_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_IDLE && state != ST_IDLE) |-> $past(grant));
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/ctx_table_access.sv
module ctx_table_access #(
  parameter int WORD_W     = 64,
  parameter int IDX_W      = 4,
  parameter int ROW_W      = 4,
  parameter int PART_ROW   = 5,
  parameter int FULL_ROW_A = 6,
  parameter int FULL_ROW_B = 9,
  parameter int KEEP_LSB   = 48,
  localparam int ADDR_W    = IDX_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_strobe,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_masked,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              cor_en,
  input  logic              mask_load,
  input  logic [WORD_W-1:0] mask_data,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [WORD_W-1:0] sram_wdata,
  input  logic [WORD_W-1:0] sram_rdata
);
  logic [WORD_W-1:0] wmask_q, old_q, wdata_q, merged;
  logic [ROW_W-1:0]  row_q;
  logic              masked_q, want, grant;

  always_ff @(posedge clk) begin
    if (rst)            wmask_q <= '0;
    else if (mask_load) wmask_q <= mask_data;
  end

  ctx_slot_gate u_gate (
    .clk(clk), .rst(rst), .slot_strobe(slot_strobe), .want(want), .grant(grant)
  );

  ctx_wb_merge #(
    .WORD_W(WORD_W), .ROW_W(ROW_W), .PART_ROW(PART_ROW), .KEEP_LSB(KEEP_LSB)
  ) u_merge (
    .old_word(old_q), .new_word(wdata_q), .wmask(wmask_q), .row(row_q),
    .masked_wr(masked_q), .merged(merged)
  );

  ctx_seq #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .ROW_W(ROW_W), .PART_ROW(PART_ROW),
    .FULL_ROW_A(FULL_ROW_A), .FULL_ROW_B(FULL_ROW_B), .KEEP_LSB(KEEP_LSB)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_masked(req_masked),
    .req_index(req_index), .req_row(req_row), .req_wdata(req_wdata), .cor_en(cor_en),
    .grant(grant), .wmask(wmask_q), .merged(merged), .sram_rdata(sram_rdata),
    .want(want), .busy(busy), .done(done), .rdata(rdata), .old_q(old_q),
    .wdata_q(wdata_q), .row_q(row_q), .masked_q(masked_q), .sram_en(sram_en),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );
endmodule

// File: tb/test_ctx_table_access.sv
module test_ctx_table_access;
  localparam int WORD_W = 64;
  localparam int IDX_W  = 4;
  localparam int ROW_W  = 4;
  localparam int ADDR_W = IDX_W + ROW_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOT   = 40;

  logic clk = 1'b0, rst = 1'b1, slot_strobe = 1'b0;
  logic req = 1'b0, req_write = 1'b0, req_masked = 1'b0, cor_en = 1'b0;
  logic [IDX_W-1:0]  req_index = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [WORD_W-1:0] req_wdata = '0, mask_data = '0;
  logic mask_load = 1'b0;
  logic busy, done, sram_en, sram_we;
  logic [WORD_W-1:0] rdata, sram_wdata, sram_rdata;
  logic [ADDR_W-1:0] sram_addr;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] exp_mem [DEPTH];
  logic [WORD_W-1:0] cur_mask;

  int checks = 0, fails = 0, cyc = 0, strobe_cnt = 0;
  int first_en = 0, last_en = 0, last_slot = -1, writes_seen = 0;
  bit in_acc = 0, wd_fired = 0;

  always #4 clk = ~clk;

  ctx_table_access i_ctx_table_access (
    .clk(clk), .rst(rst), .slot_strobe(slot_strobe), .req(req), .req_write(req_write),
    .req_masked(req_masked), .req_index(req_index), .req_row(req_row),
    .req_wdata(req_wdata), .cor_en(cor_en), .mask_load(mask_load), .mask_data(mask_data),
    .busy(busy), .done(done), .rdata(rdata), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      else         sram_rdata <= mem[sram_addr];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor and slot strobe source
  always @(negedge clk) begin
    cyc++;
    if (slot_strobe) strobe_cnt++;
    if (sram_en) begin
      if (!in_acc) begin
        in_acc = 1;
        first_en = cyc;
        check(strobe_cnt != last_slot, "R6 one start per slot", strobe_cnt, last_slot + 1);
        check(!slot_strobe, "R6 no start on strobe cycle", slot_strobe, 0);
        last_slot = strobe_cnt;
      end
      if (sram_we) writes_seen++;
      last_en = cyc;
    end
    slot_strobe = !rst && (cyc % SLOT == 0);
  end

  function automatic logic [WORD_W-1:0] clear_keep(input logic [ROW_W-1:0] row,
                                                   input logic [WORD_W-1:0] m);
    if (row == 5) return m | {16'hFFFF, 48'h0};
    return m;
  endfunction

  task automatic load_mask(input logic [WORD_W-1:0] m);
    @(negedge clk);
    mask_load = 1; mask_data = m;
    @(negedge clk);
    mask_load = 0;
    cur_mask = m;
  endtask

  task automatic access(input bit wr, input bit msk, input bit cor,
                        input logic [IDX_W-1:0] idx, input logic [ROW_W-1:0] row,
                        input logic [WORD_W-1:0] wd);
    logic [ADDR_W-1:0] a;
    logic [WORD_W-1:0] old;
    bit wb;
    int n;
    a = {idx, row};
    old = exp_mem[a];
    wb = (wr && msk) || (!wr && cor && (row == 5 || row == 6 || row == 9));
    @(negedge clk);
    req = 1; req_write = wr; req_masked = msk; cor_en = cor;
    req_index = idx; req_row = row; req_wdata = wd;
    in_acc = 0; writes_seen = 0;
    @(negedge clk);
    req = 0;
    check(busy, "R7 busy after request", busy, 1);
    n = 0;
    while (!done && n < 400) begin
      check(busy, "R7 busy until done", busy, 1);
      @(negedge clk);
      n++;
    end
    check(done && !busy, "R7 done pulse with busy low", {done, busy}, 2'b10);
    if (!wr) begin
      check(rdata == old, "R8 read data before clear", rdata, old);
    end
    if (wr && !msk)      exp_mem[a] = wd;
    else if (wr)         exp_mem[a] = (wd & ~cur_mask) | (old & cur_mask);
    else if (wb)         exp_mem[a] = old & clear_keep(row, cur_mask);
    if (wr) check(mem[a] == exp_mem[a], "R9 stored word", mem[a], exp_mem[a]);
    else if (!wb) check(mem[a] == exp_mem[a], "R4 word untouched", mem[a], exp_mem[a]);
    else if (row == 5) check(mem[a] == exp_mem[a], "R1 partial clear", mem[a], exp_mem[a]);
    else check(mem[a] == exp_mem[a], "R2 full clear", mem[a], exp_mem[a]);
    if (wb) check(((mem[a] ^ old) & cur_mask) == 0, "R3 protected bits", mem[a], old);
    check((last_en - first_en + 1) == (wb ? 4 : 1), "R5 bus window",
          last_en - first_en + 1, wb ? 4 : 1);
    check(writes_seen == ((wr || wb) ? 1 : 0), "R4 write count", writes_seen, (wr || wb) ? 1 : 0);
    @(negedge clk);
    check(!done, "R7 done is one cycle", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    wd_fired = 1;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = {$urandom, $urandom};
      exp_mem[i] = mem[i];
    end
    cur_mask = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !sram_en && !sram_we, "R10 reset state",
          {busy, done, sram_en, sram_we}, 0);
    // R10: first request waits for the first strobe
    access(0, 0, 0, 4'd1, 4'd2, '0);
    check(strobe_cnt >= 1, "R10 first access after strobe", strobe_cnt, 1);

    // directed clear-on-read cases, mask zero
    access(0, 0, 1, 4'd3, 4'd5, '0);   // R1
    access(0, 0, 1, 4'd3, 4'd6, '0);   // R2
    access(0, 0, 1, 4'd3, 4'd9, '0);   // R2
    access(0, 0, 1, 4'd3, 4'd3, '0);   // R4 other row
    access(0, 0, 0, 4'd4, 4'd5, '0);   // R4 cor off
    access(0, 0, 1, 4'd3, 4'd5, '0);   // R8 reads cleared low part
    // protected bits, R3
    load_mask(64'h00FF_0000_F0F0_000F);
    access(0, 0, 1, 4'd7, 4'd5, '0);
    access(0, 0, 1, 4'd7, 4'd9, '0);
    load_mask('1);
    access(0, 0, 1, 4'd8, 4'd6, '0);
    access(1, 1, 0, 4'd8, 4'd6, 64'h0123_4567_89AB_CDEF);
    load_mask(64'hFFFF_0000_FFFF_0000);
    access(1, 1, 0, 4'd9, 4'd0, 64'hA5A5_A5A5_A5A5_A5A5);  // R9 merge
    access(1, 0, 0, 4'd9, 4'd1, 64'h5A5A_5A5A_5A5A_5A5A);  // R9 plain
    // R6: second request in a used slot waits
    access(0, 0, 0, 4'd2, 4'd2, '0);
    access(0, 0, 0, 4'd2, 4'd3, '0);

    for (int k = 0; k < 150; k++) begin
      int op;
      if (k % 25 == 0) load_mask({$urandom, $urandom});
      op = $urandom_range(0, 3);
      access(op == 0 || op == 1, op == 1, $urandom_range(0, 1) == 1,
             IDX_W'($urandom), ROW_W'($urandom), {$urandom, $urandom});
    end

    if (!wd_fired) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule